// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from up to 26 sources and hands the most urgent one to a processor core. Every source owns a posted flag that captures an event and keeps it, plus a mask bit that decides whether the posted event may compete. Only sources that are both posted and unmasked are pending. A fixed-priority encoder then picks the lowest-numbered pending source, and the block presents that source's vector address to the core.

Software programs the mask bits and drops posted flags through an 8-bit register write port. The port has separate clear banks and mask banks, and a separate input clears every posted flag at once. A request is presented only while the global enable input is high. The core answers with an acknowledge, which drops the flag of the presented source and withdraws the request. Nesting works through the same path. Once the request has been acknowledged, raising the global enable again lets any pending source be presented, including one of higher priority than the source being serviced.

Top module: `vec_irq_ctrl`

## Requirements
- R1: An event pulse on evt_i[n] sets posted flag n on the next clock edge, and the flag stays set until it is cleared by R4 or by an acknowledge (R9).
- R2: After reset all mask bits are 0. A write with wr_addr_i = 4+b loads mask bits 8b..8b+7 from wr_data_i[7:0], with bit k of the data going to source 8b+k. A source is pending only when its posted flag and its mask bit are both 1.
- R3: Clearing a mask bit leaves the posted flag unchanged, and events that arrive while a source is masked still set its flag. Unmasking the source later makes it pending.
- R4: A write with wr_addr_i = b (0..3) clears posted flag 8b+k for each data bit k that is 1. Posted flags whose data bit is 0 are unaffected. A pulse on clr_all_i clears every posted flag.
- R5: When an event and any clear (a bank write, clr_all_i or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R6: Among pending sources, the one with the lowest number is presented. Number 0 is the highest priority and number 25 the lowest.
- R7: While irq_o is high, vec_o equals the presented source number times 4 (for example 0x0008 for source 2 and 0x0064 for source 25). While irq_o is low, vec_o is 0.
- R8: irq_o rises only on an edge where gie_i is high and some source is pending. It drops on the edge after gie_i is sampled low, or after the presented source stops pending.
- R9: An acknowledge sampled while irq_o is high clears the presented source's flag and drops irq_o on that edge. vec_o stays constant for as long as irq_o stays high, even when a higher-priority source becomes pending.
- R10: Sources 22, 23 and 24 are reserved. Events on them never post, and they never become pending.
- R11: After an acknowledge, with gie_i high, the next edge presents the highest-priority source then pending. This includes a source that posted while the earlier request was being presented.
- R12: While reset is active and directly after it, irq_o is 0 and vec_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 26 | Per-source event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | 0..3 clear banks, 4..7 mask banks |
| wr_data_i | input | 8 | Register write data |
| clr_all_i | input | 1 | Clear every posted flag |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Core acknowledge of the presented request |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 16 | Vector address of the presented source |

## Verification
The collision of interest is an event arriving on the same cycle as a clear of the same flag. The clear can come either from a clear-bank write or from the core's acknowledge of that very source. The bench provokes both cases by driving the event and the clear in one cycle. It judges the outcome at the ports. After a bank-write collision, raising the enable must present that source. After an acknowledge collision, the request must drop for one cycle and then return with the same vector.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    HOLD_IDLE = 1'b0,
    HOLD_SHOW = 1'b1
  } hold_st_e;
endpackage

// File: rtl/irq_reg_dec.sv
module irq_reg_dec #(
  parameter int NUM_SRC = 26,
  parameter int BANK_W  = 8,
  parameter int ADDR_W  = 3
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BANK_W-1:0]  data_i,
  input  logic               wr_en_i,
  input  logic               clr_all_i,
  input  logic [NUM_SRC-1:0] ack_clr_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [NUM_SRC-1:0] mask_we_o,
  output logic [NUM_SRC-1:0] mask_wd_o
);
  logic to_mask;
  assign to_mask = addr_i[ADDR_W-1];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int BK  = i / BANK_W;
    localparam int BIT = i % BANK_W;
    logic bank_hit;
    assign bank_hit     = wr_en_i && (int'(addr_i[ADDR_W-2:0]) == BK);
    assign clr_o[i]     = clr_all_i | ack_clr_i[i] | (bank_hit & ~to_mask & data_i[BIT]);
    assign mask_we_o[i] = bank_hit & to_mask;
    assign mask_wd_o[i] = data_i[BIT];
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int                NUM_SRC = 26,
  parameter logic [NUM_SRC-1:0] RSVD   = 26'h1C0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wd_i,
  output logic [NUM_SRC-1:0] posted_o,
  output logic [NUM_SRC-1:0] pending_o
);
  logic [NUM_SRC-1:0] posted_q, posted_d;
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               mask_en;

  always_comb begin
    posted_d = (evt_i | (posted_q & ~clr_i)) & ~RSVD;
    mask_en  = |mask_we_i;
    mask_d   = ((mask_q & ~mask_we_i) | (mask_wd_i & mask_we_i)) & ~RSVD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posted_q <= '0;
    end else begin
      posted_q <= posted_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign posted_o  = posted_q;
  assign pending_o = posted_q & mask_q;

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((posted_q & $past(evt_i & ~RSVD)) == $past(evt_i & ~RSVD))); // R5
  AST_POST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((posted_q & $past(posted_q & ~clr_i)) == $past(posted_q & ~clr_i))); // R3
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o & RSVD) == '0); // R10
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 26,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
    valid_o = |pend_i;
  end

  logic [NUM_SRC-1:0] below;
  assign below = (NUM_SRC'(1) << idx_o) - NUM_SRC'(1);

  always_comb begin
    if (valid_o) begin
      AST_PRIO_LOWEST: assert (pend_i[idx_o] && ((pend_i & below) == '0)); // R6
    end
  end
endmodule

// File: rtl/irq_vec_hold.sv
module irq_vec_hold
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 26,
  parameter int IDX_W   = 5,
  parameter int VEC_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gie_i,
  input  logic               ack_i,
  input  logic               valid_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] ack_clr_o
);
  hold_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic             idx_en;

  always_comb begin
    st_d   = st_q;
    idx_en = 1'b0;
    case (st_q)
      HOLD_IDLE: begin
        if (gie_i && valid_i) begin
          st_d   = HOLD_SHOW;
          idx_en = 1'b1;
        end
      end
      HOLD_SHOW: begin
        if (ack_i || !gie_i || !pend_i[idx_q]) st_d = HOLD_IDLE;
      end
      default: st_d = HOLD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HOLD_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_i;
    end
  end

  always_comb begin
    ack_clr_o = '0;
    if (st_q == HOLD_SHOW && ack_i) ack_clr_o[idx_q] = 1'b1;
  end

  assign irq_o = (st_q == HOLD_SHOW);
  assign vec_o = irq_o ? VEC_W'({idx_q, 2'b00}) : '0;
  assign idx_o = idx_q;

  AST_RISE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(gie_i)); // R8
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> (!irq_o || $stable(vec_o))); // R9
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !irq_o); // R9
  AST_QUIET_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0)); // R7
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int                 NUM_SRC = 26,
  parameter int                 BANK_W  = 8,
  parameter int                 VEC_W   = 16,
  parameter logic [NUM_SRC-1:0] RSVD    = 26'h1C0_0000,
  parameter int                 ADDR_W  = $clog2(2 * ((NUM_SRC + BANK_W - 1) / BANK_W))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [BANK_W-1:0]  wr_data_i,
  input  logic               clr_all_i,
  input  logic               gie_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] clr, mask_we, mask_wd, posted, pending, ack_clr;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx, hold_idx;

  irq_reg_dec #(.NUM_SRC(NUM_SRC), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_dec (
    .addr_i    (wr_addr_i),
    .data_i    (wr_data_i),
    .wr_en_i   (wr_en_i),
    .clr_all_i (clr_all_i),
    .ack_clr_i (ack_clr),
    .clr_o     (clr),
    .mask_we_o (mask_we),
    .mask_wd_o (mask_wd)
  );

  irq_flag_bank #(.NUM_SRC(NUM_SRC), .RSVD(RSVD)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .clr_i     (clr),
    .mask_we_i (mask_we),
    .mask_wd_i (mask_wd),
    .posted_o  (posted),
    .pending_o (pending)
  );

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .pend_i  (pending),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  irq_vec_hold #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie_i     (gie_i),
    .ack_i     (ack_i),
    .valid_i   (win_valid),
    .idx_i     (win_idx),
    .pend_i    (pending),
    .irq_o     (irq_o),
    .vec_o     (vec_o),
    .idx_o     (hold_idx),
    .ack_clr_o (ack_clr)
  );

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i && !evt_i[hold_idx]) |=> !posted[$past(hold_idx)]); // R9
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [25:0] evt;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        clr_all, gie, ack;
  logic        irq;
  logic [15:0] vec;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .clr_all_i(clr_all), .gie_i(gie), .ack_i(ack),
    .irq_o(irq), .vec_o(vec)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic e_irq, logic [15:0] e_vec);
    chk(req, {irq, vec}, {e_irq, e_vec});
  endtask

  task automatic pulse(logic [25:0] v);
    evt = v; step(); evt = '0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    clr_all = 1'b0; gie = 1'b0; ack = 1'b0;
    repeat (3) step();
    chk_out("R12 in reset", 1'b0, 16'h0);
    rst_n = 1'b1;
    step();
    chk_out("R12 after reset", 1'b0, 16'h0);
  endtask

  task automatic t_masked_post();
    gie = 1'b1;
    pulse(26'd1 << 5);
    repeat (3) step();
    chk_out("R2 masked no irq", 1'b0, 16'h0);
    wr(3'd4, 8'h20);
    step();
    chk_out("R1 R3 unmask shows", 1'b1, 16'h0014);
    do_ack();
    chk_out("R9 ack drops", 1'b0, 16'h0);
    step();
    chk_out("R9 flag gone", 1'b0, 16'h0);
  endtask

  task automatic t_mask_keeps();
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    gie = 1'b0;
    pulse(26'd1 << 7);
    step();
    chk_out("R8 no irq without gie", 1'b0, 16'h0);
    wr(3'd4, 8'h00);
    pulse(26'd1 << 3);
    step();
    wr(3'd4, 8'hFF);
    gie = 1'b1;
    step();
    chk_out("R3 R6 posted while masked", 1'b1, 16'h000C);
    do_ack();
    step();
    chk_out("R3 flag kept through mask", 1'b1, 16'h001C);
    do_ack();
  endtask

  task automatic t_priority();
    gie = 1'b1;
    pulse((26'd1 << 25) | (26'd1 << 13) | (26'd1 << 2));
    step();
    chk_out("R6 R7 src2", 1'b1, 16'h0008);
    do_ack(); step();
    chk_out("R7 src13", 1'b1, 16'h0034);
    do_ack(); step();
    chk_out("R7 src25", 1'b1, 16'h0064);
    do_ack(); step();
    chk_out("R11 none left", 1'b0, 16'h0);
  endtask

  task automatic t_reserved();
    pulse(26'h7 << 22);
    repeat (2) step();
    chk_out("R10 reserved silent", 1'b0, 16'h0);
  endtask

  task automatic t_clear();
    gie = 1'b0;
    pulse((26'd1 << 10) | (26'd1 << 18));
    wr(3'd1, 8'h04);
    gie = 1'b1;
    step();
    chk_out("R4 bank clear", 1'b1, 16'h0048);
    gie = 1'b0;
    step();
    chk_out("R8 withdraw on gie low", 1'b0, 16'h0);
    clr_all = 1'b1; step(); clr_all = 1'b0;
    gie = 1'b1;
    repeat (2) step();
    chk_out("R4 clear all", 1'b0, 16'h0);
  endtask

  task automatic t_collide();
    gie = 1'b0;
    pulse(26'd1 << 6);
    evt = 26'd1 << 6; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h40;
    step();
    evt = '0; wr_en = 1'b0;
    gie = 1'b1;
    step();
    chk_out("R5 event beats write clear", 1'b1, 16'h0018);
    ack = 1'b1; evt = 26'd1 << 6;
    step();
    ack = 1'b0; evt = '0;
    chk_out("R9 ack drops in collision", 1'b0, 16'h0);
    step();
    chk_out("R5 event beats ack", 1'b1, 16'h0018);
    do_ack(); step();
    chk_out("R5 cleared after", 1'b0, 16'h0);
  endtask

  task automatic t_nest();
    gie = 1'b1;
    pulse(26'd1 << 20);
    step();
    chk_out("R7 src20", 1'b1, 16'h0050);
    pulse(26'd1 << 1);
    chk_out("R9 held vs higher", 1'b1, 16'h0050);
    step();
    chk_out("R9 still held", 1'b1, 16'h0050);
    do_ack();
    chk_out("R9 dropped", 1'b0, 16'h0);
    step();
    chk_out("R11 nested higher", 1'b1, 16'h0004);
    do_ack(); step();
    chk_out("R11 idle after", 1'b0, 16'h0);
  endtask

  initial begin
    t_reset();
    t_masked_post();
    t_mask_keeps();
    t_priority();
    t_reserved();
    t_clear();
    t_collide();
    t_nest();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule